// File: doc/BRIEF.md
# Complementary PWM Pair with Deadtime and Fractional Dithering

This block generates one pair of pulse-width-modulated outputs, a top output and a bottom output, from a 16-bit up-counter. The counter has its own period. Each output is high while the counter sits inside a window. The window is bounded by a turn-on compare value and a turn-off compare value, so the same hardware produces edge-aligned, center-aligned and asymmetric waveforms. The pair either runs complementary, with the bottom the inverse of the top, or as two independent channels, each with its own window.

Each output has its own deadtime count. An output may only go high after its raw request has been high for that many clocks, and it drops as soon as the request drops. Two 5-bit fractional accumulators give a finer average period and finer edge placement. One accumulator stretches a period by one clock each time it carries. The other delays both edges of every window by one clock in the period that follows a carry. New period, compare, deadtime and fraction values are written to shadow inputs. They take effect only at a period boundary, or at any time while the block is disabled.

Top module: `pwm_pair_dt`

## Requirements
- R1: While rst_n is low at a clock edge, or enable is low at a clock edge, both outputs are low and count is 0 after that edge.
- R2: With enable high and no fractional carry, count steps 0,1,…,N−1 and then returns to 0, where N is the active period value. A period value of 0 behaves as 1.
- R3: The top request is high while top_rise+s ≤ count < top_fall+s, where s is the current edge extension (0 or 1). An output register follows the request one clock later.
- R4: Period, compare, deadtime and fraction inputs are copied into the active set only on the clock edge that wraps count to 0, or on every edge while enable is low. A change made mid-period does not alter the period in progress.
- R5: With complementary high, the bottom request is the inverse of the top request.
- R6: With complementary low, the bottom request is high while bot_rise+s ≤ count < bot_fall+s.
- R7: The top output goes high only on a cycle whose request has already been high for at least top_dead earlier consecutive cycles. It goes low on the first cycle its request is low.
- R8: The bottom output applies the same rule as R7 with bot_dead, independently of top_dead.
- R9: If a deadtime is equal to or longer than the request pulse, that output stays low for the whole pulse.
- R10: At each wrap, period_frac is added to a 5-bit accumulator. A carry out of bit 4 makes the next period one clock longer. With period_frac = 16, any 8 consecutive periods last 8N+4 clocks.
- R11: At each wrap, edge_frac is added to a second 5-bit accumulator. A carry sets s = 1 for the next period, otherwise s = 0.
- R12: In complementary mode, pwm_top and pwm_bot are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Runs the counter; low forces outputs low and reloads the active set |
| complementary | input | 1 | 1 = complementary pair, 0 = independent channels |
| period | input | 16 | Shadow period in clocks |
| top_rise | input | 16 | Shadow count at which the top request rises |
| top_fall | input | 16 | Shadow count at which the top request falls |
| bot_rise | input | 16 | Shadow count at which the bottom request rises (independent mode) |
| bot_fall | input | 16 | Shadow count at which the bottom request falls (independent mode) |
| top_dead | input | 10 | Shadow deadtime before the top output turns on |
| bot_dead | input | 10 | Shadow deadtime before the bottom output turns on |
| period_frac | input | 5 | Shadow fraction added to the period accumulator each period |
| edge_frac | input | 5 | Shadow fraction added to the edge accumulator each period |
| count | output | 16 | Current counter value |
| pwm_top | output | 1 | Top output |
| pwm_bot | output | 1 | Bottom output |

## Verification
The pair is driven with an edge-aligned complementary pattern that has unequal top and bottom deadtimes. Its per-period high counts show whether each deadtime is applied to its own output. A center-aligned window shows whether the turn-on and turn-off comparisons use the right inequality. An independent asymmetric pattern shows whether the bottom channel reads its own window rather than the inverted top. A deadtime that equals the pulse width shows whether such a pulse is suppressed completely. A mid-period period change, and runs with non-zero period and edge fractions, show shadow timing and carry placement. Both are measured as period lengths and compared every clock against a behavioural model.

// File: rtl/pwm_dt_pkg.sv
// Package: shared mode encoding and channel indices for the PWM pair.
// Assumes channel 0 is the top output and channel 1 is the bottom output.
package pwm_dt_pkg;

    typedef enum logic {
        PAIR_INDEP = 1'b0,
        PAIR_COMPL = 1'b1
    } pair_mode_e;

    localparam int CH_TOP = 0;
    localparam int CH_BOT = 1;
    localparam int NUM_CH = 2;

endpackage

// File: rtl/pwm_timebase.sv
// Module: pwm_timebase
// Counter, shadow-to-active transfer and both fractional accumulators.
// Assumes the shadow inputs are stable around the wrap edge. While enable is
// low the active set tracks the shadows and the counter and accumulators clear.
module pwm_timebase #(
    parameter int CW  = 16,
    parameter int FW  = 5,
    parameter int DTW = 10,
    parameter int NCH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic [CW-1:0]            period_sh,
    input  logic [NCH-1:0][CW-1:0]   rise_sh,
    input  logic [NCH-1:0][CW-1:0]   fall_sh,
    input  logic [NCH-1:0][DTW-1:0]  dead_sh,
    input  logic [FW-1:0]            pfrac_sh,
    input  logic [FW-1:0]            efrac_sh,
    output logic [CW-1:0]            cnt,
    output logic [NCH-1:0][CW-1:0]   rise_act,
    output logic [NCH-1:0][CW-1:0]   fall_act,
    output logic [NCH-1:0][DTW-1:0]  dead_act,
    output logic                     edge_ext
);

    localparam logic [CW:0] ONE_W = (CW+1)'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_act_q;
    logic [FW-1:0] pacc_q;
    logic [FW-1:0] eacc_q;
    logic          pext_q;
    logic          eext_q;
    logic [CW:0]   per_eff;
    logic [CW:0]   last_w;
    logic          wrap;
    logic [FW:0]   pacc_sum;
    logic [FW:0]   eacc_sum;

    // Effective period (0 acts as 1) and the last count of this period.
    always_comb begin
        per_eff  = (per_act_q == '0) ? ONE_W : {1'b0, per_act_q};
        last_w   = per_eff - ONE_W + (CW+1)'(pext_q);
        wrap     = ({1'b0, cnt_q} == last_w);
        pacc_sum = {1'b0, pacc_q} + {1'b0, pfrac_sh};
        eacc_sum = {1'b0, eacc_q} + {1'b0, efrac_sh};
    end

    // Counter, accumulators and period extension flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pacc_q <= '0;
            eacc_q <= '0;
            pext_q <= 1'b0;
            eext_q <= 1'b0;
        end else if (!enable) begin
            cnt_q  <= '0;
            pacc_q <= '0;
            eacc_q <= '0;
            pext_q <= 1'b0;
            eext_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            pacc_q <= pacc_sum[FW-1:0];
            eacc_q <= eacc_sum[FW-1:0];
            pext_q <= pacc_sum[FW];
            eext_q <= eacc_sum[FW];
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // Active period register: loads from its shadow at a boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_act_q <= '0;
        end else if (!enable || wrap) begin
            per_act_q <= period_sh;
        end
    end

    // Per-channel active compare and deadtime registers, same load rule.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_act
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rise_act[ch] <= '0;
                fall_act[ch] <= '0;
                dead_act[ch] <= '0;
            end else if (!enable || wrap) begin
                rise_act[ch] <= rise_sh[ch];
                fall_act[ch] <= fall_sh[ch];
                dead_act[ch] <= dead_sh[ch];
            end
        end
    end

    assign cnt      = cnt_q;
    assign edge_ext = eext_q;

endmodule

// File: rtl/pwm_window.sv
// Module: pwm_window
// Compares the counter with a turn-on and a turn-off value, both shifted by
// the edge extension. Purely combinational; assumes rise <= fall for a pulse.
module pwm_window #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] rise,
    input  logic [CW-1:0] fall,
    input  logic          shift,
    output logic          req
);

    logic [CW:0] lo;
    logic [CW:0] hi;
    logic [CW:0] cnt_w;

    // Shifted window bounds in one extra bit so a shift never wraps.
    always_comb begin
        cnt_w = {1'b0, cnt};
        lo    = {1'b0, rise} + (CW+1)'(shift);
        hi    = {1'b0, fall} + (CW+1)'(shift);
        req   = (cnt_w >= lo) && (cnt_w < hi);
    end

endmodule

// File: rtl/pwm_deadtime.sv
// Module: pwm_deadtime
// Holds an output low until its request has been high for 'dead' earlier
// consecutive cycles; releases it at once when the request falls.
// Assumes the run counter saturating at its maximum is acceptable.
module pwm_deadtime #(
    parameter int DTW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           req,
    input  logic [DTW-1:0] dead,
    output logic           pwm
);

    localparam logic [DTW-1:0] RUN_MAX = '1;

    logic [DTW-1:0] run_q;
    logic           pwm_q;

    // Count consecutive cycles of high request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || !req) begin
            run_q <= '0;
        end else if (run_q != RUN_MAX) begin
            run_q <= run_q + 1'b1;
        end
    end

    // Register the gated output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm_q <= 1'b0;
        end else begin
            pwm_q <= enable && req && (run_q >= dead);
        end
    end

    assign pwm = pwm_q;

endmodule

// File: rtl/pwm_pair_dt.sv
// Module: pwm_pair_dt (top)
// One PWM pair: timebase, two compare windows, mode selection for the bottom
// request and one deadtime stage per output. Assumes a single clock domain.
module pwm_pair_dt
    import pwm_dt_pkg::*;
#(
    parameter int CW  = 16,
    parameter int FW  = 5,
    parameter int DTW = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           complementary,
    input  logic [CW-1:0]  period,
    input  logic [CW-1:0]  top_rise,
    input  logic [CW-1:0]  top_fall,
    input  logic [CW-1:0]  bot_rise,
    input  logic [CW-1:0]  bot_fall,
    input  logic [DTW-1:0] top_dead,
    input  logic [DTW-1:0] bot_dead,
    input  logic [FW-1:0]  period_frac,
    input  logic [FW-1:0]  edge_frac,
    output logic [CW-1:0]  count,
    output logic           pwm_top,
    output logic           pwm_bot
);

    logic [NUM_CH-1:0][CW-1:0]  rise_sh;
    logic [NUM_CH-1:0][CW-1:0]  fall_sh;
    logic [NUM_CH-1:0][DTW-1:0] dead_sh;
    logic [NUM_CH-1:0][CW-1:0]  rise_act;
    logic [NUM_CH-1:0][CW-1:0]  fall_act;
    logic [NUM_CH-1:0][DTW-1:0] dead_act;
    logic [NUM_CH-1:0]          win_req;
    logic [NUM_CH-1:0]          ch_req;
    logic [NUM_CH-1:0]          ch_pwm;
    logic [CW-1:0]              cnt;
    logic                       edge_ext;
    pair_mode_e                 mode;

    // Gather the shadow inputs into per-channel arrays.
    always_comb begin
        rise_sh[CH_TOP] = top_rise;
        fall_sh[CH_TOP] = top_fall;
        dead_sh[CH_TOP] = top_dead;
        rise_sh[CH_BOT] = bot_rise;
        fall_sh[CH_BOT] = bot_fall;
        dead_sh[CH_BOT] = bot_dead;
    end

    pwm_timebase #(
        .CW (CW),
        .FW (FW),
        .DTW(DTW),
        .NCH(NUM_CH)
    ) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .period_sh(period),
        .rise_sh  (rise_sh),
        .fall_sh  (fall_sh),
        .dead_sh  (dead_sh),
        .pfrac_sh (period_frac),
        .efrac_sh (edge_frac),
        .cnt      (cnt),
        .rise_act (rise_act),
        .fall_act (fall_act),
        .dead_act (dead_act),
        .edge_ext (edge_ext)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_win
        pwm_window #(.CW(CW)) u_window (
            .cnt  (cnt),
            .rise (rise_act[ch]),
            .fall (fall_act[ch]),
            .shift(edge_ext),
            .req  (win_req[ch])
        );
    end

    // Pick the bottom request: inverted top or its own window.
    always_comb begin
        mode           = pair_mode_e'(complementary);
        ch_req[CH_TOP] = win_req[CH_TOP];
        ch_req[CH_BOT] = (mode == PAIR_COMPL) ? !win_req[CH_TOP] : win_req[CH_BOT];
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_dead
        pwm_deadtime #(.DTW(DTW)) u_dead (
            .clk   (clk),
            .rst_n (rst_n),
            .enable(enable),
            .req   (ch_req[ch]),
            .dead  (dead_act[ch]),
            .pwm   (ch_pwm[ch])
        );
    end

    assign count   = cnt;
    assign pwm_top = ch_pwm[CH_TOP];
    assign pwm_bot = ch_pwm[CH_BOT];

endmodule

// File: rtl/pwm_pair_dt_chk.sv
// Module: pwm_pair_dt_chk
// Port-level properties of the PWM pair, bound to every instance of the top.
module pwm_pair_dt_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          complementary,
    input logic [CW-1:0] count,
    input logic          pwm_top,
    input logic          pwm_bot
);

    // R1: a disabled edge leaves both outputs low.
    a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pwm_top && !pwm_bot));

    // R1: a disabled edge leaves the counter at zero.
    a_r1_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0));

    // R2: an enabled edge either advances the counter by one or wraps it.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ((count == $past(count) + 1'b1) || (count == '0)));

    // R12: complementary outputs never overlap.
    a_r12_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(complementary) |-> !(pwm_top && pwm_bot));

endmodule

bind pwm_pair_dt pwm_pair_dt_chk #(.CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .complementary(complementary),
    .count        (count),
    .pwm_top      (pwm_top),
    .pwm_bot      (pwm_bot)
);

// File: tb/test_pwm_pair_dt.sv
`timescale 1ns/1ps
module test_pwm_pair_dt;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        complementary = 1'b1;
    logic [15:0] period = 16'd10;
    logic [15:0] top_rise = '0, top_fall = '0, bot_rise = '0, bot_fall = '0;
    logic [9:0]  top_dead = '0, bot_dead = '0;
    logic [4:0]  period_frac = '0, edge_frac = '0;
    logic [15:0] count;
    logic        pwm_top, pwm_bot;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 1'b0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    // behavioural model state
    int m_cnt = 0, m_per = 0, m_pacc = 0, m_eacc = 0, m_pext = 0, m_eext = 0;
    int m_rise[2], m_fall[2], m_dead[2], m_run[2];
    bit m_out[2];

    always #4 clk = ~clk;

    pwm_pair_dt i_pwm_pair_dt (
        .clk(clk), .rst_n(rst_n), .enable(enable), .complementary(complementary),
        .period(period), .top_rise(top_rise), .top_fall(top_fall),
        .bot_rise(bot_rise), .bot_fall(bot_fall), .top_dead(top_dead),
        .bot_dead(bot_dead), .period_frac(period_frac), .edge_frac(edge_frac),
        .count(count), .pwm_top(pwm_top), .pwm_bot(pwm_bot)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void load_shadow();
        m_per = period;
        m_rise[0] = top_rise; m_fall[0] = top_fall; m_dead[0] = top_dead;
        m_rise[1] = bot_rise; m_fall[1] = bot_fall; m_dead[1] = bot_dead;
    endfunction

    // Reference model built from the requirements, advanced on each edge.
    always @(posedge clk) begin
        bit req[2];
        int last, p_eff;
        if (!rst_n) begin
            m_cnt = 0; m_per = 0; m_pacc = 0; m_eacc = 0; m_pext = 0; m_eext = 0;
            for (int c = 0; c < 2; c++) begin
                m_rise[c] = 0; m_fall[c] = 0; m_dead[c] = 0; m_run[c] = 0; m_out[c] = 0;
            end
        end else if (!enable) begin
            m_cnt = 0; m_pacc = 0; m_eacc = 0; m_pext = 0; m_eext = 0;
            load_shadow();
            for (int c = 0; c < 2; c++) begin m_run[c] = 0; m_out[c] = 0; end
        end else begin
            for (int c = 0; c < 2; c++)
                req[c] = (m_cnt >= m_rise[c] + m_eext) && (m_cnt < m_fall[c] + m_eext);
            if (complementary) req[1] = !req[0];
            for (int c = 0; c < 2; c++) begin
                m_out[c] = req[c] && (m_run[c] >= m_dead[c]);
                m_run[c] = req[c] ? ((m_run[c] < 1023) ? m_run[c] + 1 : 1023) : 0;
            end
            p_eff = (m_per == 0) ? 1 : m_per;
            last  = p_eff - 1 + m_pext;
            if (m_cnt == last) begin
                m_cnt = 0;
                load_shadow();
                m_pacc = m_pacc + int'(period_frac);
                m_eacc = m_eacc + int'(edge_frac);
                m_pext = m_pacc / 32; m_pacc = m_pacc % 32;
                m_eext = m_eacc / 32; m_eacc = m_eacc % 32;
            end else begin
                m_cnt = m_cnt + 1;
            end
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk({cur_req, " count"}, int'(count), m_cnt);
            chk({cur_req, " top"}, int'(pwm_top), int'(m_out[0]));
            chk({cur_req, " bot"}, int'(pwm_bot), int'(m_out[1]));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        enable = 1'b0;
        cycles(2);
        enable = 1'b1;
    endtask

    // Count high cycles of each output over n clocks.
    task automatic measure(input int n, output int tops, output int bots, output int both);
        tops = 0; bots = 0; both = 0;
        repeat (n) begin
            @(negedge clk);
            tops += int'(pwm_top);
            bots += int'(pwm_bot);
            both += int'(pwm_top && pwm_bot);
        end
    endtask

    initial begin
        int t, b, o, cyc, zeros, mx;
        // R1: reset state
        cycles(3);
        chk("R1 reset top", int'(pwm_top), 0);
        chk("R1 reset bot", int'(pwm_bot), 0);
        chk("R1 reset count", int'(count), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cycles(3);
        chk("R1 idle count", int'(count), 0);

        // R3 R5 R7 R8 R12: edge-aligned complementary, unequal deadtimes
        cur_req = "R7";
        complementary = 1'b1; period = 16'd10;
        top_rise = 16'd0; top_fall = 16'd4; top_dead = 10'd1; bot_dead = 10'd2;
        restart();
        cycles(25);
        measure(50, t, b, o);
        chk("R7 top high cycles", t, 15);
        chk("R8 bot high cycles", b, 20);
        chk("R12 overlap cycles", o, 0);

        // R3: center-aligned window, no deadtime
        cur_req = "R3";
        period = 16'd20; top_rise = 16'd5; top_fall = 16'd15; top_dead = 10'd0; bot_dead = 10'd0;
        restart();
        cycles(22);
        measure(40, t, b, o);
        chk("R3 center top", t, 20);
        chk("R5 center bot", b, 20);

        // R6 R8: independent asymmetric windows
        cur_req = "R6";
        complementary = 1'b0;
        top_rise = 16'd2; top_fall = 16'd9; bot_rise = 16'd12; bot_fall = 16'd17;
        top_dead = 10'd0; bot_dead = 10'd3;
        restart();
        cycles(22);
        measure(40, t, b, o);
        chk("R6 indep top", t, 14);
        chk("R8 indep bot", b, 4);

        // R9: deadtime equal to pulse keeps top low
        cur_req = "R9";
        complementary = 1'b1; period = 16'd10;
        top_rise = 16'd0; top_fall = 16'd3; top_dead = 10'd3; bot_dead = 10'd0;
        restart();
        measure(40, t, b, o);
        chk("R9 top suppressed", t, 0);

        // R4: period shadow change mid-period takes effect at the wrap
        cur_req = "R4";
        top_dead = 10'd0;
        @(negedge clk);
        while (count != 16'd2) @(negedge clk);
        period = 16'd6;
        mx = 0;
        @(negedge clk);
        while (count != 16'd0) begin
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
        end
        chk("R4 old period kept", mx, 9);
        mx = 0;
        @(negedge clk);
        while (count != 16'd0) begin
            if (int'(count) > mx) mx = int'(count);
            @(negedge clk);
        end
        chk("R4 new period used", mx, 5);

        // R2: period 0 behaves as 1
        cur_req = "R2";
        period = 16'd0;
        restart();
        cycles(5);
        chk("R2 zero period count", int'(count), 0);

        // R10: period fraction 16 adds 4 clocks over 8 periods
        cur_req = "R10";
        period = 16'd10; period_frac = 5'd16;
        restart();
        cycles(30);
        while (count != 16'd0) @(negedge clk);
        cyc = 0; zeros = 0;
        while (zeros < 8) begin
            @(negedge clk);
            cyc++;
            if (count == 16'd0) zeros++;
        end
        chk("R10 eight periods", cyc, 84);

        // R11: edge fraction dithers edges; model compare each clock
        cur_req = "R11";
        period_frac = 5'd0; edge_frac = 5'd11;
        top_rise = 16'd2; top_fall = 16'd6; top_dead = 10'd1; bot_dead = 10'd1;
        restart();
        cycles(120);
        period_frac = 5'd7;
        cycles(120);

        // R1: disable mid-run drops outputs on the next edge
        cur_req = "R1";
        enable = 1'b0;
        @(negedge clk);
        chk("R1 disable top", int'(pwm_top), 0);
        chk("R1 disable bot", int'(pwm_bot), 0);
        chk("R1 disable count", int'(count), 0);
        cycles(3);

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(8ns * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule